// File: doc/BRIEF.md
# Parallel Row Sum-of-Absolute-Differences Unit

This block produces the sum of absolute differences between two rows of sixteen unsigned 8-bit pixels. A motion search engine uses it to compare a row or column of the current macroblock against a candidate row from the reference frame. The block has no subtractor and no absolute-value stage. For each pixel pair it uses the carry of a single addition to find the smaller operand, and it bit-inverts that operand. Every pair then totals 255 plus its absolute difference, and all pairs go straight into one multi-operand adder.

The offset left by the inversions is cancelled by a constant row that is fixed at design time. That row pushes the sum of all offsets up to exactly one bit above the result width, and that bit is discarded at the end. There are three pipeline stages: pair compare and invert, carry-save reduction of 33 rows to two, and a final carry-propagate add. The block accepts a new pair of rows on every clock.

Top module: `sad_row_unit`

## Requirements
- R1: For each pair, the carry-out of the 8-bit addition (~A + B) with carry-in 0 selects the operand to invert. A carry of 1 (B > A) inverts A and passes B unchanged. A carry of 0 (A >= B, including A == B) passes A unchanged and inverts B.
- R2: The two operands selected for each pair add up to exactly 255 + |A - B|, so a pair with A == B contributes 0 to the result.
- R3: A constant row of value 2^(q+n) - m*2^n + m joins the 32 operand rows, where n = 8, m = 16 and q = ceil(log2 m); this is 16 at the defaults. The total of all 33 rows then has its bit 12 (weight 4096) set, and that bit is dropped.
- R4: When `out_valid` is 1, `sad` equals the 12-bit value sum over i of |a_i - b_i|, where pixel i occupies bits [8i+7:8i] of `pix_a` and `pix_b`.
- R5: A vector presented with `in_valid` high at a clock edge appears on `out_valid`/`sad` after the third rising edge, counting that edge as the first.
- R6: A new vector can be presented on every cycle. Back-to-back vectors come out on consecutive cycles in order, each with its own result.
- R7: A synchronous active-high `rst` clears every valid stage and `sad`; `out_valid` is 0 while reset is held and afterwards until a valid vector has passed through.
- R8: All-zero pixels against all-255 pixels yield 4080 in either operand order, and identical rows yield 0.
- R9: A cycle with `in_valid` low produces `out_valid` low three edges later and leaves `sad` holding the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies pix_a and pix_b |
| pix_a | input | 128 | Sixteen unsigned 8-bit pixels of the current row, pixel i at bits [8i+7:8i] |
| pix_b | input | 128 | Sixteen unsigned 8-bit pixels of the candidate row, same packing |
| out_valid | output | 1 | sad holds a fresh result this cycle |
| sad | output | 12 | Sum of absolute differences of the row pair |

## Verification
The interesting coincidence is a new vector entering the compare stage in the same cycle that an older vector finishes the final add and a third is being reduced. Gaps in valid can also land between them. The bench provokes this with long back-to-back random streams in which `in_valid` is occasionally dropped. Every cycle it compares `out_valid` and `sad` against a three-deep behavioural pipeline that computes the absolute differences with plain integer arithmetic. That catches any result that leaks between neighbouring vectors and any bubble that updates `sad`.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Datapath dimensions. PIX_W must be a power of two for the carry tree.
    localparam int PIX_W     = 8;
    localparam int NUM_PAIRS = 16;

    localparam int IDX_W    = $clog2(NUM_PAIRS);
    localparam int SUM_W    = PIX_W + IDX_W;          // width of the final result
    localparam int ROW_W    = SUM_W + 1;              // keeps the discarded offset bit
    localparam int NUM_OPS  = 2 * NUM_PAIRS;          // operand rows out of stage 1
    localparam int NUM_ROWS = NUM_OPS + 1;            // plus the correction row
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int MAX_SAD  = NUM_PAIRS * PIX_MAX;

    // Offset cancellation: pushes the sum of all pair offsets to 2^SUM_W.
    localparam int CORR_VAL = (1 << SUM_W) - NUM_PAIRS * (1 << PIX_W) + NUM_PAIRS;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [ROW_W-1:0] row_t;
    typedef logic [SUM_W-1:0] sad_t;

    typedef struct packed {
        logic                     vld;
        pix_t [NUM_OPS-1:0]       ops;
    } cmp_stage_t;

    typedef struct packed {
        logic vld;
        row_t sum_row;
        row_t car_row;
    } red_stage_t;

    // Carry-out of (x + y), carry-in 0, as a tree of generate/propagate merges.
    function automatic logic group_carry(input pix_t x, input pix_t y);
        pix_t g;
        pix_t p;
        g = x & y;
        p = x | y;
        for (int span = 1; span < PIX_W; span = span * 2) begin
            for (int base = 0; base + span < PIX_W; base = base + 2 * span) begin
                g[base] = g[base + span] | (p[base + span] & g[base]);
                p[base] = p[base + span] & p[base];
            end
        end
        return g[0];
    endfunction

endpackage

// File: rtl/sad_pair_select.sv
module sad_pair_select
    import sad_pkg::*;
(
    input  pix_t a_in,
    input  pix_t b_in,
    output pix_t a_out,
    output pix_t b_out
);
    logic b_gt_a;

    always_comb begin
        b_gt_a = group_carry(~a_in, b_in);
        a_out  = b_gt_a ? ~a_in : a_in;
        b_out  = b_gt_a ? b_in  : ~b_in;
    end

    // R1 / R2: selected operands carry exactly the absolute difference plus 255
    logic [PIX_W:0] pair_total;
    logic [PIX_W:0] pair_expect;
    always_comb begin
        pair_total  = {1'b0, a_out} + {1'b0, b_out};
        pair_expect = (a_in > b_in) ? ({1'b0, a_in} - {1'b0, b_in})
                                    : ({1'b0, b_in} - {1'b0, a_in});
        pair_expect = pair_expect + (PIX_W+1)'(PIX_MAX);
        a_r2_pair_offset: assert (pair_total == pair_expect)
            else $error("pair total %0d expected %0d", pair_total, pair_expect);
        a_r1_one_passes: assert ((a_out == a_in) != (b_out == b_in))
            else $error("exactly one operand must pass unchanged");
    end

endmodule

// File: rtl/sad_csa_reduce.sv
module sad_csa_reduce
    import sad_pkg::*;
(
    input  pix_t [NUM_OPS-1:0] ops,
    output row_t               sum_row,
    output row_t               car_row
);
    always_comb begin
        row_t s;
        row_t c;
        row_t r;
        row_t ns;
        s = row_t'(CORR_VAL);
        c = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            r  = row_t'(ops[k]);
            ns = s ^ c ^ r;
            c  = ((s & c) | (s & r) | (c & r)) << 1;
            s  = ns;
        end
        sum_row = s;
        car_row = c;
    end

endmodule

// File: rtl/sad_final_add.sv
module sad_final_add
    import sad_pkg::*;
(
    input  row_t sum_row,
    input  row_t car_row,
    output sad_t result,
    output logic offset_bit
);
    row_t total;

    always_comb begin
        total      = sum_row + car_row;
        result     = total[SUM_W-1:0];
        offset_bit = total[SUM_W];
    end

endmodule

// File: rtl/sad_row_unit.sv
module sad_row_unit
    import sad_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NUM_PAIRS*PIX_W-1:0] pix_a,
    input  logic [NUM_PAIRS*PIX_W-1:0] pix_b,
    output logic                       out_valid,
    output logic [SUM_W-1:0]           sad
);
    pix_t [NUM_OPS-1:0] sel_ops;
    cmp_stage_t         s1_q;
    red_stage_t         s2_q;
    row_t               red_sum;
    row_t               red_car;
    sad_t               add_res;
    logic               add_ofs;
    logic               vld_q;
    sad_t               sad_q;

    // Stage 1: per-pair compare and invert
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        sad_pair_select u_sel (
            .a_in  (pix_a[i*PIX_W +: PIX_W]),
            .b_in  (pix_b[i*PIX_W +: PIX_W]),
            .a_out (sel_ops[2*i]),
            .b_out (sel_ops[2*i+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q.vld <= 1'b0;
        end else begin
            s1_q.vld <= in_valid;
        end
        s1_q.ops <= sel_ops;
    end

    // Stage 2: correction row plus carry-save reduction
    sad_csa_reduce u_red (
        .ops     (s1_q.ops),
        .sum_row (red_sum),
        .car_row (red_car)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q.vld <= 1'b0;
        end else begin
            s2_q.vld <= s1_q.vld;
        end
        s2_q.sum_row <= red_sum;
        s2_q.car_row <= red_car;
    end

    // Stage 3: carry-propagate add, offset bit dropped
    sad_final_add u_add (
        .sum_row    (s2_q.sum_row),
        .car_row    (s2_q.car_row),
        .result     (add_res),
        .offset_bit (add_ofs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            sad_q <= '0;
        end else begin
            vld_q <= s2_q.vld;
            if (s2_q.vld) begin
                sad_q <= add_res;
            end
        end
    end

    assign out_valid = vld_q;
    assign sad       = sad_q;

    // R3: offset of all rows lands exactly on the dropped bit
    a_r3_offset_bit: assert property (@(posedge clk) disable iff (rst)
        s2_q.vld |-> add_ofs)
        else $error("offset bit not set in final total");

    // R4: result can never exceed sixteen maximal differences
    a_r4_sad_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(sad) <= MAX_SAD))
        else $error("sad out of range");

    // R5: valid advances one stage per edge
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        s1_q.vld |=> s2_q.vld)
        else $error("valid lost between stage 1 and 2");

    a_r5_out_follows: assert property (@(posedge clk) disable iff (rst)
        s2_q.vld |=> out_valid)
        else $error("valid lost at output stage");

    // R9: a bubble leaves the result unchanged
    a_r9_hold_on_bubble: assert property (@(posedge clk) disable iff (rst)
        !s2_q.vld |=> $stable(sad))
        else $error("sad changed on a bubble");

    // R7: no valid output directly after reset release without input history
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && sad == '0))
        else $error("reset did not clear output");

endmodule

// File: tb/sad_row_unit_tb.sv
module sad_row_unit_tb;
    import sad_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       in_valid = 1'b0;
    logic [NUM_PAIRS*PIX_W-1:0] pix_a = '0;
    logic [NUM_PAIRS*PIX_W-1:0] pix_b = '0;
    logic                       out_valid;
    logic [SUM_W-1:0]           sad;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    // behavioural model pipeline
    int m_vld [3];
    int m_sad [3];
    int m_out_sad;

    always #(CLK_PERIOD/2) clk = ~clk;

    sad_row_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pix_a     (pix_a),
        .pix_b     (pix_b),
        .out_valid (out_valid),
        .sad       (sad)
    );

    function automatic int ref_sad(input logic [NUM_PAIRS*PIX_W-1:0] a,
                                   input logic [NUM_PAIRS*PIX_W-1:0] b);
        int acc = 0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            int x = int'(a[i*PIX_W +: PIX_W]);
            int y = int'(b[i*PIX_W +: PIX_W]);
            acc += (x > y) ? x - y : y - x;
        end
        return acc;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                m_vld[k] = 0;
                m_sad[k] = 0;
            end
            m_out_sad = 0;
        end else begin
            if (m_vld[1] != 0) m_out_sad = m_sad[1];
            m_vld[2] = m_vld[1];
            m_sad[2] = m_sad[1];
            m_vld[1] = m_vld[0];
            m_sad[1] = m_sad[0];
            m_vld[0] = int'(in_valid);
            m_sad[0] = ref_sad(pix_a, pix_b);
        end
    end

    // per-cycle comparison against the model (R4, R5, R6)
    always @(negedge clk) begin
        if (!rst && cycles > 0) begin
            check("R5 valid", int'(out_valid), m_vld[2]);
            check("R4/R6 sad", int'(sad), m_out_sad);
        end
    end

    task automatic drive(input logic v,
                         input logic [NUM_PAIRS*PIX_W-1:0] a,
                         input logic [NUM_PAIRS*PIX_W-1:0] b);
        @(negedge clk);
        in_valid = v;
        pix_a    = a;
        pix_b    = b;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, '0, '0);
    endtask

    function automatic logic [NUM_PAIRS*PIX_W-1:0] rand_row();
        logic [NUM_PAIRS*PIX_W-1:0] r;
        for (int i = 0; i < NUM_PAIRS; i++) r[i*PIX_W +: PIX_W] = PIX_W'($urandom);
        return r;
    endfunction

    // drive one vector and check the dedicated result after three edges
    task automatic single(input string tag,
                          input logic [NUM_PAIRS*PIX_W-1:0] a,
                          input logic [NUM_PAIRS*PIX_W-1:0] b,
                          input int exp);
        drive(1'b1, a, b);
        idle(2);
        @(negedge clk);
        check({tag, " out_valid"}, int'(out_valid), 1);
        check({tag, " sad"}, int'(sad), exp);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * WATCHDOG);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NUM_PAIRS*PIX_W-1:0] ra;
        logic [NUM_PAIRS*PIX_W-1:0] rb;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 out_valid in reset", int'(out_valid), 0);
        check("R7 sad in reset", int'(sad), 0);
        rst = 1'b0;
        idle(3);
        check("R7 out_valid after reset", int'(out_valid), 0);

        // R8: extremes and identical rows
        single("R8 zero vs max", '0, '1, MAX_SAD);
        single("R8 max vs zero", '1, '0, MAX_SAD);
        ra = rand_row();
        single("R8 identical", ra, ra, 0);

        // R1/R2: single differing pair, each direction, equality elsewhere
        ra = '0; rb = '0;
        ra[3*PIX_W +: PIX_W] = 8'd200; rb[3*PIX_W +: PIX_W] = 8'd45;
        single("R1 A greater", ra, rb, 155);
        single("R1 B greater", rb, ra, 155);
        ra = '0; rb = '0;
        ra[15*PIX_W +: PIX_W] = 8'd128; rb[15*PIX_W +: PIX_W] = 8'd127;
        single("R2 adjacent values", ra, rb, 1);

        // R3: every pair at full difference stresses the offset bit
        ra = '0; rb = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            ra[i*PIX_W +: PIX_W] = (i % 2 == 0) ? 8'd255 : 8'd0;
            rb[i*PIX_W +: PIX_W] = (i % 2 == 0) ? 8'd0   : 8'd255;
        end
        single("R3 mixed full difference", ra, rb, MAX_SAD);

        // R9: bubbles keep sad
        idle(4);
        check("R9 hold after bubbles", int'(sad), MAX_SAD);
        check("R9 valid low on bubbles", int'(out_valid), 0);

        // R6: back-to-back stream with occasional gaps, checked every cycle
        for (int n = 0; n < 400; n++) begin
            drive(($urandom % 8) != 0, rand_row(), rand_row());
        end
        // R6: dense stream with no gaps
        for (int n = 0; n < 100; n++) begin
            drive(1'b1, rand_row(), rand_row());
        end
        idle(5);

        // R7: reset in the middle of traffic
        drive(1'b1, '0, '1);
        drive(1'b1, '1, '0);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R7 mid-stream reset valid", int'(out_valid), 0);
        check("R7 mid-stream reset sad", int'(sad), 0);
        idle(4);
        check("R7 flushed stages stay idle", int'(out_valid), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule